// File: doc/BRIEF.md
# Docking Detect Sequencer with Interrupt

This block watches the two active-low detect lines of a docking connector and drives the two voltage-sense lines that go to the same connector. Nothing is attached while both detect lines read high. A dock is seen when both lines read low. The sequencer then waits out a debounce interval, chosen by one configuration bit, to let the contacts settle. After that it runs a type test. On the station, one detect line is tied to ground. The other is tied to one of the two sense lines, and which sense line it is tied to tells the station's supply type. The sequencer raises each sense line in turn and watches whether the looped detect line follows it. From that it reports a 3.3 V station, a 5 V station or an unrecognised device.

Every step of interest sets a bit in a 4-bit pending register. A 4-bit enable mask decides which pending bits may drive the interrupt request. Software clears pending bits by writing ones to them. Once a station is docked, a sustained high level on the grounded detect line counts as a removal. A removal drops both sense lines and returns the sequencer to idle.

Top module: `dock_detect_seq`

## Requirements
- R1: After a synchronous reset, both sense outputs are low. The pending register is 0h, the interrupt is low, the type code is 0 (none) and the enable mask is 6h.
- R2: A dock is recognised only when both detect inputs are low at once. If only one of them is held low, no pending bit is ever set.
- R3: After recognition, the sequencer waits 1024 clock cycles when the select input is 0, and 8192 cycles when it is 1. If either detect line goes high during that wait, the sequencer returns to idle and sets no event.
- R4: The type test first drives the low-voltage sense output high for 4 cycles, with the other sense output low. If the first detect line then reads high, the type code becomes 1 (3.3 V) and the low-voltage sense output stays high.
- R5: If the first step fails, the high-voltage sense output is driven high for 4 cycles. A high first detect line then gives type code 2 (5 V). Otherwise the type code becomes 3 (error) and both sense outputs return low.
- R6: The event bits in the pending register are: bit 0 set when the debounce wait ends, bit 1 set when a 3.3 V or 5 V station is identified, and bit 3 set on an error result.
- R7: While docked, if the grounded (second) detect line reads high for a full debounce interval, pending bit 2 is set. At the same time both sense outputs go low and the type code returns to 0.
- R8: The two sense outputs are never high in the same cycle.
- R9: A clear write with a 1 in a bit position clears that pending bit in the next cycle and leaves every other pending bit as it was.
- R10: The interrupt output equals the OR of pending AND mask. It changes in the same cycle as the pending register or the mask, and it stays high until the enabling pending bits are cleared or masked off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_a_n | input | 1 | Detect line looped to a sense line on the station, active low |
| det_b_n | input | 1 | Detect line grounded on the station, active low |
| long_dly_sel | input | 1 | Debounce select: 0 = 1024 cycles, 1 = 8192 cycles |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 4 | New enable mask value |
| clr_we | input | 1 | Write strobe for pending clear |
| clr_wdata | input | 4 | Ones clear the matching pending bits |
| sense_lo | output | 1 | Low-voltage sense drive |
| sense_hi | output | 1 | High-voltage sense drive |
| vtype | output | 2 | Type code: 0 none, 1 3.3 V, 2 5 V, 3 error |
| pending | output | 4 | Pending event bits |
| evt_mask | output | 4 | Current enable mask |
| irq | output | 1 | Interrupt request |

## Verification
Each detect input passes through a two-flop synchroniser before the sequencer sees it, so a detect change affects the sequencer's decision on the third rising edge after the change. A sequencer transition updates the sense lines, the type code, the pending bits and the interrupt together on the same edge. A clear or mask write shows up one edge after it is presented. The bench's behavioural model uses the same latencies, so each output can be compared at every falling edge. At the end of each scenario the bench also checks the values it expects from the requirements.

// File: rtl/dock_pkg.sv
package dock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT     = 3'd1,
    ST_PROBE_LO = 3'd2,
    ST_PROBE_HI = 3'd3,
    ST_DOCKED   = 3'd4
  } dock_st_e;

  typedef enum logic [1:0] {
    VT_NONE = 2'd0,
    VT_3V3  = 2'd1,
    VT_5V   = 2'd2,
    VT_ERR  = 2'd3
  } vtype_e;

  localparam int NUM_EV    = 4;
  localparam int EV_ATTACH = 0;
  localparam int EV_DONE   = 1;
  localparam int EV_REMOVE = 2;
  localparam int EV_ERROR  = 3;

endpackage

// File: rtl/dock_sync.sv
module dock_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= {W{RST_VAL}};
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= {W{RST_VAL}};
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dock_seq.sv
module dock_seq
  import dock_pkg::*;
#(
  parameter int SHORT_CYC  = 1024,
  parameter int LONG_CYC   = 8192,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_a_s,
  input  logic              det_b_s,
  input  logic              long_sel,
  output logic              sense_lo,
  output logic              sense_hi,
  output logic [1:0]        vtype,
  output logic [NUM_EV-1:0] ev_set
);

  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LAST  = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST   = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  dock_st_e       st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic           lo_n, hi_n;
  vtype_e         vt, vt_n;
  logic [CW-1:0]  dly_last;

  assign dly_last = long_sel ? LONG_LAST : SHORT_LAST;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    lo_n   = sense_lo;
    hi_n   = sense_hi;
    vt_n   = vt;
    ev_set = '0;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (!det_a_s && !det_b_s) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (det_a_s || det_b_s) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (cnt == dly_last) begin
          st_n  = ST_PROBE_LO;
          cnt_n = '0;
          lo_n  = 1'b1;
          ev_set[EV_ATTACH] = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_PROBE_LO: begin
        if (det_b_s) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
          lo_n  = 1'b0;
        end else if (cnt == SETTLE_LAST) begin
          cnt_n = '0;
          if (det_a_s) begin
            st_n = ST_DOCKED;
            vt_n = VT_3V3;
            ev_set[EV_DONE] = 1'b1;
          end else begin
            st_n = ST_PROBE_HI;
            lo_n = 1'b0;
            hi_n = 1'b1;
          end
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_PROBE_HI: begin
        if (det_b_s) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
          hi_n  = 1'b0;
        end else if (cnt == SETTLE_LAST) begin
          cnt_n = '0;
          st_n  = ST_DOCKED;
          if (det_a_s) begin
            vt_n = VT_5V;
            ev_set[EV_DONE] = 1'b1;
          end else begin
            hi_n = 1'b0;
            vt_n = VT_ERR;
            ev_set[EV_ERROR] = 1'b1;
          end
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_DOCKED: begin
        if (det_b_s) begin
          if (cnt == dly_last) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
            lo_n  = 1'b0;
            hi_n  = 1'b0;
            vt_n  = VT_NONE;
            ev_set[EV_REMOVE] = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end else begin
          cnt_n = '0;
        end
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
        lo_n  = 1'b0;
        hi_n  = 1'b0;
        vt_n  = VT_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sense_lo <= 1'b0;
      sense_hi <= 1'b0;
      vt       <= VT_NONE;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      sense_lo <= lo_n;
      sense_hi <= hi_n;
      vt       <= vt_n;
    end
  end

  assign vtype = vt;

endmodule

// File: rtl/dock_evt.sv
module dock_evt #(
  parameter int           N        = 4,
  parameter logic [N-1:0] MASK_RST = 4'h6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev_set,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         clr_we,
  input  logic [N-1:0] clr_wdata,
  output logic [N-1:0] pending,
  output logic [N-1:0] mask,
  output logic         irq
);

  logic [N-1:0] pend_n;
  logic [N-1:0] mask_n;
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_wdata : '0;
  assign mask_n  = mask_we ? mask_wdata : mask;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pend_n[i] = ev_set[i] | (pending[i] & ~clr_eff[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      mask    <= MASK_RST;
      irq     <= 1'b0;
    end else begin
      pending <= pend_n;
      mask    <= mask_n;
      irq     <= |(pend_n & mask_n);
    end
  end

endmodule

// File: rtl/dock_detect_seq.sv
module dock_detect_seq
  import dock_pkg::*;
#(
  parameter int SHORT_CYC   = 1024,
  parameter int LONG_CYC    = 8192,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       det_a_n,
  input  logic       det_b_n,
  input  logic       long_dly_sel,
  input  logic       mask_we,
  input  logic [3:0] mask_wdata,
  input  logic       clr_we,
  input  logic [3:0] clr_wdata,
  output logic       sense_lo,
  output logic       sense_hi,
  output logic [1:0] vtype,
  output logic [3:0] pending,
  output logic [3:0] evt_mask,
  output logic       irq
);

  logic [1:0]        det_s;
  logic [NUM_EV-1:0] ev_set;

  dock_sync #(
    .W       (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({det_b_n, det_a_n}),
    .q   (det_s)
  );

  dock_seq #(
    .SHORT_CYC  (SHORT_CYC),
    .LONG_CYC   (LONG_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .det_a_s  (det_s[0]),
    .det_b_s  (det_s[1]),
    .long_sel (long_dly_sel),
    .sense_lo (sense_lo),
    .sense_hi (sense_hi),
    .vtype    (vtype),
    .ev_set   (ev_set)
  );

  dock_evt #(
    .N        (NUM_EV),
    .MASK_RST (4'h6)
  ) u_evt (
    .clk        (clk),
    .rst        (rst),
    .ev_set     (ev_set),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_we     (clr_we),
    .clr_wdata  (clr_wdata),
    .pending    (pending),
    .mask       (evt_mask),
    .irq        (irq)
  );

endmodule

// File: rtl/dock_detect_seq_chk.sv
module dock_detect_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr_we,
  input logic [3:0] clr_wdata,
  input logic       sense_lo,
  input logic       sense_hi,
  input logic [1:0] vtype,
  input logic [3:0] pending,
  input logic [3:0] evt_mask,
  input logic       irq
);

  // R8
  sense_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sense_lo && sense_hi));

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(pending & evt_mask)));

  // R9
  no_spont_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pending) & ~pending & ~($past(clr_we) ? $past(clr_wdata) : 4'h0)) == 4'h0);

  // R5
  err_sense_low_chk: assert property (@(posedge clk) disable iff (rst)
    (vtype == 2'd3) |-> (!sense_lo && !sense_hi));

  // R7
  removal_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending[2]) |-> (vtype == 2'd0 && !sense_lo && !sense_hi));

  // R4
  type33_sense_chk: assert property (@(posedge clk) disable iff (rst)
    (vtype == 2'd1) |-> (sense_lo && !sense_hi));

endmodule

bind dock_detect_seq dock_detect_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_we    (clr_we),
  .clr_wdata (clr_wdata),
  .sense_lo  (sense_lo),
  .sense_hi  (sense_hi),
  .vtype     (vtype),
  .pending   (pending),
  .evt_mask  (evt_mask),
  .irq       (irq)
);

// File: tb/dock_detect_seq_tb.sv
`timescale 1ns/1ps
module dock_detect_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       long_dly_sel = 1'b0;
  logic       mask_we = 1'b0;
  logic [3:0] mask_wdata = 4'h0;
  logic       clr_we = 1'b0;
  logic [3:0] clr_wdata = 4'h0;
  logic       det_a_n, det_b_n;
  logic       sense_lo, sense_hi, irq;
  logic [1:0] vtype;
  logic [3:0] pending, evt_mask;

  // station: 0 none, 1 3.3V, 2 5V, 3 unknown, 4 only B low, 5 only A low
  int kind = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign det_a_n = (kind == 1) ? sense_lo :
                   (kind == 2) ? sense_hi :
                   (kind == 3 || kind == 5) ? 1'b0 : 1'b1;
  assign det_b_n = (kind == 1 || kind == 2 || kind == 3 || kind == 4) ? 1'b0 : 1'b1;

  dock_detect_seq u_dut (
    .clk(clk), .rst(rst), .det_a_n(det_a_n), .det_b_n(det_b_n),
    .long_dly_sel(long_dly_sel), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .sense_lo(sense_lo),
    .sense_hi(sense_hi), .vtype(vtype), .pending(pending),
    .evt_mask(evt_mask), .irq(irq)
  );

  // behavioural reference model
  int   m_st = 0, m_cnt = 0, m_vt = 0;
  bit   m_lo = 0, m_hi = 0, m_irq = 0;
  bit   m_a1 = 1, m_a2 = 1, m_b1 = 1, m_b2 = 1;
  logic [3:0] m_pend = 0, m_mask = 4'h6;

  always @(posedge clk) begin : model
    int last;
    logic [3:0] ev;
    ev = 4'h0;
    last = long_dly_sel ? 8191 : 1023;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_vt = 0; m_lo = 0; m_hi = 0; m_irq = 0;
      m_a1 = 1; m_a2 = 1; m_b1 = 1; m_b2 = 1; m_pend = 0; m_mask = 4'h6;
    end else begin
      case (m_st)
        0: begin m_cnt = 0; if (!m_a2 && !m_b2) m_st = 1; end
        1: if (m_a2 || m_b2) begin m_st = 0; m_cnt = 0; end
           else if (m_cnt == last) begin m_st = 2; m_cnt = 0; m_lo = 1; ev[0] = 1; end
           else m_cnt++;
        2: if (m_b2) begin m_st = 0; m_cnt = 0; m_lo = 0; end
           else if (m_cnt == 3) begin
             m_cnt = 0;
             if (m_a2) begin m_st = 4; m_vt = 1; ev[1] = 1; end
             else begin m_st = 3; m_lo = 0; m_hi = 1; end
           end else m_cnt++;
        3: if (m_b2) begin m_st = 0; m_cnt = 0; m_hi = 0; end
           else if (m_cnt == 3) begin
             m_cnt = 0; m_st = 4;
             if (m_a2) begin m_vt = 2; ev[1] = 1; end
             else begin m_hi = 0; m_vt = 3; ev[3] = 1; end
           end else m_cnt++;
        default: if (m_b2) begin
             if (m_cnt == last) begin
               m_st = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_vt = 0; ev[2] = 1;
             end else m_cnt++;
           end else m_cnt = 0;
      endcase
      m_pend = (m_pend & ~(clr_we ? clr_wdata : 4'h0)) | ev;
      if (mask_we) m_mask = mask_wdata;
      m_irq = |(m_pend & m_mask);
      m_a2 = m_a1; m_b2 = m_b1;
      m_a1 = det_a_n; m_b1 = det_b_n;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 sense_lo", sense_lo, m_lo);
      chk("R8 sense_hi", sense_hi, m_hi);
      chk("R5 vtype", vtype, m_vt);
      chk("R9 pending", pending, m_pend);
      chk("R10 irq", irq, m_irq);
      chk("R10 mask", evt_mask, m_mask);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(logic [3:0] v);
    clr_wdata = v; clr_we = 1'b1;
    cyc(1);
    clr_we = 1'b0; clr_wdata = 4'h0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 sense", {sense_hi, sense_lo}, 0);
    chk("R1 pending", pending, 0);
    chk("R1 irq", irq, 0);
    chk("R1 vtype", vtype, 0);
    chk("R1 mask", evt_mask, 6);

    // R2 single line low never docks
    kind = 4; cyc(1500);
    chk("R2 only B low", pending, 0);
    kind = 5; cyc(1500);
    chk("R2 only A low", pending, 0);
    kind = 0; cyc(10);

    // R3 bounce during short wait
    kind = 1; cyc(500);
    kind = 0; cyc(30);
    chk("R3 bounce no event", pending, 0);

    // R4 3.3V station, short wait
    kind = 1; cyc(1000);
    chk("R3 still waiting", pending, 0);
    cyc(60);
    chk("R4 vtype 3v3", vtype, 1);
    chk("R4 sense_lo held", sense_lo, 1);
    chk("R6 attach+done", pending, 3);
    chk("R10 irq on done", irq, 1);

    // R9 partial clear
    clear(4'h1);
    chk("R9 partial clear", pending, 2);
    clear(4'hF);
    chk("R9 clear all", pending, 0);
    chk("R10 irq dropped", irq, 0);

    // R7 removal
    kind = 0; cyc(1100);
    chk("R7 removal event", pending, 4);
    chk("R7 vtype none", vtype, 0);
    chk("R7 sense low", {sense_hi, sense_lo}, 0);
    clear(4'hF);

    // R5 5V station, long wait
    long_dly_sel = 1'b1;
    kind = 2; cyc(1100);
    chk("R3 long wait pending", pending, 0);
    cyc(7150);
    chk("R5 vtype 5v", vtype, 2);
    chk("R5 sense_hi held", sense_hi, 1);
    chk("R6 attach+done 5v", pending, 3);
    clear(4'hF);
    kind = 0; cyc(8250);
    chk("R7 long removal", pending, 4);
    clear(4'hF);

    // R5 unknown device with mask cleared
    long_dly_sel = 1'b0;
    mask_wdata = 4'h0; mask_we = 1'b1; cyc(1); mask_we = 1'b0;
    kind = 3; cyc(1080);
    chk("R5 vtype error", vtype, 3);
    chk("R5 error sense low", {sense_hi, sense_lo}, 0);
    chk("R6 attach+error", pending, 9);
    chk("R10 masked irq", irq, 0);
    mask_wdata = 4'h8; mask_we = 1'b1; cyc(1); mask_we = 1'b0;
    chk("R10 unmask irq", irq, 1);
    kind = 0; cyc(1100);
    chk("R7 removal after error", pending, 13);
    chk("R10 irq held", irq, 1);
    clear(4'hF);
    chk("R9 final clear", pending, 0);
    cyc(5);
    finish_run();
  end

endmodule